// File: doc/BRIEF.md
# HDLC Transmit Flag Sequencer

This block turns a byte stream into a bit-serial HDLC line signal. Bytes arrive over a valid/ready handshake, and a marker flags the final byte of each frame. The block sends one line bit for every cycle in which the bit enable is high. It sends each byte least significant bit first. It applies zero-bit insertion to frame content and surrounds every frame with the 01111110 flag. Whenever no frame is waiting, the line carries a continuous run of flags.

The number of flags between back-to-back frames is set by a 4-bit count and a flag-sharing enable. Sharing only takes effect while a separate qualifier input is high. With sharing active, one flag can close one frame and also open the next. The configuration is captured when the last content bit of a frame leaves the serializer. A change made while a frame is being sent therefore applies to the gap that follows that frame, and never to the frame itself.

Top module: `hdlc_tx_flagseq`

## Requirements
- R1: During reset `tx_bit` is 1 and `in_ready` is 1.
- R2: While no frame is pending the line repeats the flag 01111110. Flag bits are never zero-stuffed, so a flag shows six ones in a row.
- R3: Each frame's bytes go out in order, each byte least significant bit first. A receiver that removes flags and stuffed zeros recovers exactly the bytes that were accepted.
- R4: Within frame content a 0 follows every run of five 1 bits. This holds across byte boundaries and after the final content bit. Content never puts six ones in a row on the line.
- R5: With effective sharing off, the number of flags between two back-to-back frames is N+2: one closing flag, N extra flags and one opening flag. N is the 4-bit count, and N=15 gives 17.
- R6: With effective sharing on and N=0, exactly one flag separates two back-to-back frames.
- R7: With effective sharing on and N>0, N+1 flags separate two back-to-back frames.
- R8: Effective sharing is the AND of the sharing enable and the qualifier. With the qualifier low the R5 count applies, whatever the enable is set to.
- R9: The configuration is sampled at the moment a frame's last content bit, or a trailing stuffed zero, has been sent. Values applied and withdrawn earlier in that frame have no effect.
- R10: `tx_bit` changes only at a clock edge where `bit_en` is 1. It carries exactly one line bit per such edge.
- R11: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. After an accept `in_ready` is low for at least one cycle, and it falls only after an accept.
- R12: After reset the first frame is preceded by at least one flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Bit enable; one line bit per enabled cycle |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | Byte valid |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block can accept a byte |
| cfg_flag_cnt | input | 4 | Inter-frame flag count N |
| cfg_share_en | input | 1 | Flag-sharing enable |
| cfg_share_qual | input | 1 | Qualifier that allows sharing to take effect |
| tx_bit | output | 1 | Serial line bit |

## Verification
Each line bit is registered once, so the bit for an enabled edge is visible on `tx_bit` right after that edge. The bench records the bit at the following falling edge, and only for edges where it had driven `bit_en` high. It feeds these bits to its own flag-detecting, destuffing receiver. This lets frame contents and inter-frame flag counts be compared without regard to how fast bits are enabled. `in_ready` responds on the edge after an accept, so the bench checks it at the falling edge that follows that accept. Configuration values are changed only after the second byte or the last byte of a frame has been accepted. At that point the previous gap has already been latched and the current frame's end is still at least eight enabled bits away.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [0:0] {
    ST_FLAG = 1'b0,
    ST_DATA = 1'b1
  } tx_state_e;

  localparam logic [7:0] FLAG_PATTERN = 8'h7E;
  localparam logic [2:0] STUFF_RUN    = 3'd5;
endpackage

// File: rtl/hdlc_tx_gap_calc.sv
module hdlc_tx_gap_calc #(
  parameter int CNT_W = 4,
  parameter int GAP_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             share_en,
  input  logic             share_qual,
  output logic [GAP_W-1:0] need
);
  logic             share_act;
  logic [GAP_W-1:0] cnt_ext;

  assign share_act = share_en & share_qual;
  assign cnt_ext   = GAP_W'(cnt);

  always_comb begin
    if (share_act) begin
      need = (cnt == '0) ? GAP_W'(1) : cnt_ext + GAP_W'(1);
    end else begin
      need = cnt_ext + GAP_W'(2);
    end
  end
endmodule

// File: rtl/hdlc_tx_hold.sv
module hdlc_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_last,
  output logic              hold_full
);
  logic [DATA_W-1:0] data_d, data_q;
  logic              last_d, last_q;
  logic              full_d, full_q;
  logic              accept;

  assign in_ready = ~full_q;
  assign accept   = in_valid & ~full_q;

  always_comb begin
    data_d = data_q;
    last_d = last_q;
    full_d = full_q;
    if (accept) begin
      data_d = in_data;
      last_d = in_last;
      full_d = 1'b1;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      last_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      data_q <= data_d;
      last_q <= last_d;
      full_q <= full_d;
    end
  end

  assign hold_data = data_q;
  assign hold_last = last_q;
  assign hold_full = full_q;
endmodule

// File: rtl/hdlc_tx_serial.sv
module hdlc_tx_serial
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_last,
  input  logic [GAP_W-1:0]  gap_need,
  output logic              take,
  output logic              tx_bit
);
  localparam int                BCNT_W    = $clog2(DATA_W);
  localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(DATA_W - 1);

  tx_state_e         state_d, state_q;
  logic [DATA_W-1:0] sh_d, sh_q;
  logic              last_d, last_q;
  logic [BCNT_W-1:0] bcnt_d, bcnt_q;
  logic [2:0]        ones_d, ones_q;
  logic              bdone_d, bdone_q;
  logic [2:0]        fbit_d, fbit_q;
  logic [GAP_W-1:0]  sent_d, sent_q;
  logic [GAP_W-1:0]  req_d, req_q;
  logic              tx_d, tx_q;
  logic [GAP_W-1:0]  sent_inc;
  logic              cur_bit;
  logic              advance;

  assign cur_bit  = sh_q[bcnt_q];
  assign sent_inc = (sent_q == '1) ? sent_q : sent_q + GAP_W'(1);

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    last_d  = last_q;
    bcnt_d  = bcnt_q;
    ones_d  = ones_q;
    bdone_d = bdone_q;
    fbit_d  = fbit_q;
    sent_d  = sent_q;
    req_d   = req_q;
    tx_d    = tx_q;
    take    = 1'b0;
    advance = 1'b0;
    if (bit_en) begin
      case (state_q)
        ST_FLAG: begin
          tx_d = FLAG_PATTERN[fbit_q];
          if (fbit_q == 3'd7) begin
            fbit_d = '0;
            sent_d = sent_inc;
            if (hold_full && (sent_inc >= req_q)) begin
              state_d = ST_DATA;
              take    = 1'b1;
              sh_d    = hold_data;
              last_d  = hold_last;
              bcnt_d  = '0;
              ones_d  = '0;
              bdone_d = 1'b0;
            end
          end else begin
            fbit_d = fbit_q + 3'd1;
          end
        end
        default: begin
          if (ones_q == STUFF_RUN) begin
            tx_d   = 1'b0;
            ones_d = '0;
            advance = bdone_q;
          end else begin
            tx_d   = cur_bit;
            ones_d = cur_bit ? ones_q + 3'd1 : 3'd0;
            if (bcnt_q == BCNT_LAST) begin
              if (cur_bit && (ones_q == STUFF_RUN - 3'd1)) begin
                bdone_d = 1'b1;
              end else begin
                advance = 1'b1;
              end
            end else begin
              bcnt_d = bcnt_q + BCNT_W'(1);
            end
          end
          if (advance) begin
            if (!last_q && hold_full) begin
              take    = 1'b1;
              sh_d    = hold_data;
              last_d  = hold_last;
              bcnt_d  = '0;
              bdone_d = 1'b0;
            end else begin
              state_d = ST_FLAG;
              fbit_d  = '0;
              sent_d  = '0;
              req_d   = gap_need;
              bdone_d = 1'b0;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FLAG;
      sh_q    <= '0;
      last_q  <= 1'b0;
      bcnt_q  <= '0;
      ones_q  <= '0;
      bdone_q <= 1'b0;
      fbit_q  <= '0;
      sent_q  <= '0;
      req_q   <= GAP_W'(1);
      tx_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      last_q  <= last_d;
      bcnt_q  <= bcnt_d;
      ones_q  <= ones_d;
      bdone_q <= bdone_d;
      fbit_q  <= fbit_d;
      sent_q  <= sent_d;
      req_q   <= req_d;
      tx_q    <= tx_d;
    end
  end

  assign tx_bit = tx_q;
endmodule

// File: rtl/hdlc_tx_flagseq.sv
module hdlc_tx_flagseq #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [CNT_W-1:0]  cfg_flag_cnt,
  input  logic              cfg_share_en,
  input  logic              cfg_share_qual,
  output logic              tx_bit
);
  localparam int GAP_W = CNT_W + 1;

  logic [DATA_W-1:0] hold_data;
  logic              hold_last;
  logic              hold_full;
  logic              take;
  logic [GAP_W-1:0]  gap_need;

  hdlc_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .take      (take),
    .hold_data (hold_data),
    .hold_last (hold_last),
    .hold_full (hold_full)
  );

  hdlc_tx_gap_calc #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_gap (
    .cnt        (cfg_flag_cnt),
    .share_en   (cfg_share_en),
    .share_qual (cfg_share_qual),
    .need       (gap_need)
  );

  hdlc_tx_serial #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .hold_last (hold_last),
    .gap_need  (gap_need),
    .take      (take),
    .tx_bit    (tx_bit)
  );
endmodule

// File: rtl/hdlc_tx_flagseq_chk.sv
module hdlc_tx_flagseq_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_valid,
  input logic in_ready,
  input logic tx_bit
);
  logic       en_d;
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      run_q <= '0;
    end else begin
      en_d <= bit_en;
      if (en_d) begin
        run_q <= tx_bit ? ((run_q == 3'd7) ? run_q : run_q + 3'd1) : 3'd0;
      end
    end
  end

  // R4 and R2: no run longer than the six ones of a flag
  a_r4_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 3'd6);

  // R10: line bit holds when no bit enable
  a_r10_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R11: an accept closes the ready window
  a_r11_accept_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R11: ready falls only after an accept
  a_r11_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));
endmodule

bind hdlc_tx_flagseq hdlc_tx_flagseq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_en   (bit_en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .tx_bit   (tx_bit)
);

// File: tb/tb_hdlc_tx_flagseq.sv
`timescale 1ns/1ps
module tb_hdlc_tx_flagseq;
  logic       clk;
  logic       rst_n;
  logic       bit_en;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_last;
  logic       in_ready;
  logic [3:0] cfg_flag_cnt;
  logic       cfg_share_en;
  logic       cfg_share_qual;
  logic       tx_bit;

  hdlc_tx_flagseq dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_en         (bit_en),
    .in_data        (in_data),
    .in_valid       (in_valid),
    .in_last        (in_last),
    .in_ready       (in_ready),
    .cfg_flag_cnt   (cfg_flag_cnt),
    .cfg_share_en   (cfg_share_en),
    .cfg_share_qual (cfg_share_qual),
    .tx_bit         (tx_bit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // receiver model state
  bit         dq[$];
  logic [7:0] rx_bytes[$];
  int         rx_len[$];
  int         rx_gap[$];
  int         ones_r = 0;
  int         gap_now = 0;
  int         stuff_seen = 0;
  int         over_run = 0;
  int         misalign = 0;
  int         stable_bad = 0;
  int         hs_bad = 0;
  logic       en_seen = 1'b0;
  logic       prev_bit = 1'b1;

  task automatic decode(input bit b);
    if (b) begin
      ones_r++;
      if (ones_r > 6) over_run++;
      dq.push_back(1'b1);
    end else if (ones_r == 5) begin
      ones_r = 0;
      stuff_seen++;
    end else if (ones_r == 6) begin
      ones_r = 0;
      for (int k = 0; k < 7; k++) if (dq.size() > 0) void'(dq.pop_back());
      if (dq.size() > 0) begin
        if (dq.size() % 8 != 0) misalign++;
        for (int i = 0; i < dq.size() / 8; i++) begin
          logic [7:0] v;
          for (int k = 0; k < 8; k++) v[k] = dq[i*8 + k];
          rx_bytes.push_back(v);
        end
        rx_len.push_back(dq.size() / 8);
        rx_gap.push_back(gap_now);
        dq.delete();
        gap_now = 1;
      end else begin
        gap_now++;
      end
    end else begin
      ones_r = 0;
      dq.push_back(1'b0);
    end
  endtask

  always @(posedge clk) en_seen <= bit_en & rst_n;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_bit = tx_bit;
    end else begin
      if (en_seen) decode(tx_bit);
      else if (tx_bit !== prev_bit) stable_bad++;
      prev_bit = tx_bit;
    end
  end

  initial begin
    bit_en = 1'b0;
    forever begin
      @(negedge clk);
      bit_en = rst_n && (($urandom % 4) != 0);
    end
  end

  // expected frames
  logic [7:0] exp_bytes[$];
  int         exp_len[$];
  int         exp_gap[$];
  string      exp_tag[$];
  logic [7:0] fr[0:7];
  int         prev_need = -1;
  string      prev_tag = "R12";

  function automatic int gap_of(input int n, input bit sh, input bit q);
    if (sh && q) return (n == 0) ? 1 : n + 1;
    return n + 2;
  endfunction

  function automatic string tag_of(input int n, input bit sh, input bit q, input bit decoy);
    if (decoy) return "R9";
    if (sh && !q) return "R8";
    if (!(sh && q)) return "R5";
    return (n == 0) ? "R6" : "R7";
  endfunction

  task automatic send_frame(input int len, input int n, input bit sh, input bit q,
                            input bit decoy);
    exp_len.push_back(len);
    exp_gap.push_back(prev_need);
    exp_tag.push_back(prev_tag);
    for (int i = 0; i < len; i++) exp_bytes.push_back(fr[i]);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (in_ready) hs_bad++;
      in_valid = 1'b0;
      if (i == 1 && decoy && i != len - 1) begin
        cfg_flag_cnt   = 4'($urandom);
        cfg_share_en   = 1'($urandom);
        cfg_share_qual = 1'($urandom);
      end
      if (i == len - 1) begin
        cfg_flag_cnt   = 4'(n);
        cfg_share_en   = sh;
        cfg_share_qual = q;
      end
    end
    prev_need = gap_of(n, sh, q);
    prev_tag  = tag_of(n, sh, q, decoy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n          = 1'b0;
    in_valid       = 1'b0;
    in_last        = 1'b0;
    in_data        = '0;
    cfg_flag_cnt   = '0;
    cfg_share_en   = 1'b0;
    cfg_share_qual = 1'b0;
    repeat (4) @(negedge clk);
    check(tx_bit == 1'b1, "R1", "tx_bit in reset", int'(tx_bit), 1);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (120) @(negedge clk);
    check(rx_len.size() == 0 && dq.size() < 8, "R2", "idle frames seen", rx_len.size(), 0);
    check(gap_now >= 3, "R2", "idle flags seen", gap_now, 3);

    // directed: long ones run across bytes, gap after: plain N=0
    fr[0] = 8'hFF; fr[1] = 8'hFF; fr[2] = 8'hFF;
    send_frame(3, 0, 1'b0, 1'b0, 1'b0);
    // content ending in five ones, gap after: shared N=0
    fr[0] = 8'h00; fr[1] = 8'hF8;
    send_frame(2, 0, 1'b1, 1'b1, 1'b0);
    // flag-like content, gap after: shared N=3
    fr[0] = 8'h7E; fr[1] = 8'h7E; fr[2] = 8'h55;
    send_frame(3, 3, 1'b1, 1'b1, 1'b0);
    // enable without qualifier, N=3
    fr[0] = 8'h3F; fr[1] = 8'hFC;
    send_frame(2, 3, 1'b1, 1'b0, 1'b0);
    // largest count, plain
    fr[0] = 8'hA5; fr[1] = 8'hFF; fr[2] = 8'h01;
    send_frame(3, 15, 1'b0, 1'b1, 1'b0);
    // random frames with mid-frame configuration churn
    for (int f = 0; f < 22; f++) begin
      int len;
      len = 3 + int'($urandom % 5);
      for (int i = 0; i < len; i++) begin
        fr[i] = 8'($urandom);
        if (($urandom % 3) == 0) fr[i] = 8'hFF;
      end
      send_frame(len, int'($urandom % 16), 1'($urandom), 1'($urandom), 1'b1);
    end
    // final frame, its closing flag ends decoding
    fr[0] = 8'h12; fr[1] = 8'h34;
    send_frame(2, 0, 1'b0, 1'b0, 1'b0);
    repeat (600) @(negedge clk);

    check(rx_len.size() == exp_len.size(), "R3", "frame count", rx_len.size(), exp_len.size());
    begin
      int pos;
      pos = 0;
      for (int f = 0; f < exp_len.size() && f < rx_len.size(); f++) begin
        int mism;
        int a_v;
        int e_v;
        mism = 0; a_v = 0; e_v = 0;
        check(rx_len[f] == exp_len[f], "R3", $sformatf("frame %0d length", f), rx_len[f], exp_len[f]);
        if (rx_len[f] == exp_len[f]) begin
          for (int i = 0; i < exp_len[f]; i++) begin
            if (rx_bytes[pos + i] !== exp_bytes[pos + i] && mism == 0) begin
              mism = 1; a_v = int'(rx_bytes[pos + i]); e_v = int'(exp_bytes[pos + i]);
            end
          end
          check(mism == 0, "R3", $sformatf("frame %0d byte value", f), a_v, e_v);
        end
        pos += exp_len[f];
        if (f == 0) begin
          check(rx_gap[f] >= 1, "R12", "flags before first frame", rx_gap[f], 1);
        end else begin
          check(rx_gap[f] == exp_gap[f], exp_tag[f], $sformatf("flags before frame %0d", f),
                rx_gap[f], exp_gap[f]);
        end
      end
    end
    check(stuff_seen > 0, "R4", "stuffed zeros observed", stuff_seen, 1);
    check(over_run == 0, "R4", "runs over six ones", over_run, 0);
    check(misalign == 0, "R4", "frames not byte aligned", misalign, 0);
    check(stable_bad == 0, "R10", "changes without bit enable", stable_bad, 0);
    check(hs_bad == 0, "R11", "ready high after accept", hs_bad, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule